// File: doc/BRIEF.md
# Interrupt Route Table with Live Retargeting

This block keeps two routing tables for an interrupt router. The first gives each interrupt source a target core. The second gives each group of sources a parent line. Software writes both tables as 32-bit words, and each word carries four byte-wide entries. Once a word is accepted, the block decodes its entries one per cycle, in ascending order, and stores the decoded indices. It also keeps the raw word so that a read returns exactly what was written. Core entries are decoded in one of two ways, chosen by a mode pin. In one-hot mode the index is the lowest set bit, and an empty byte or a lowest bit at position 4 or above falls back to 0. In binary mode the byte is the index itself.

The block also watches the router's raw pending vector. Suppose a core entry moves a source to a different core while that source is pending. The block then sends two events on a valid/ready event stream. First it sends a lower event for the old core. It then updates the table. Last it sends a raise event for the new core. An event stays on the stream, unchanged, until the router accepts it, and the table walk waits during that time. The configuration write port is also valid/ready: a write is taken on a cycle where both valid and ready are high. Ready stays low from the cycle after acceptance until the last entry of the word has been handled.

Top module: `irq_route_retarget`

## Requirements
- R1: After reset every source targets core 0, every group uses parent line 0, every raw word reads back as 0, `ev_valid` is low and `cfg_ready` is high.
- R2: In a word written at address A, bits 8i+7..8i hold entry i, for i from 0 to 3, and that entry applies to source (or group) 4A+i. Group g covers sources g*8 to g*8+7.
- R3: A one-hot entry decodes to the position of its lowest set bit. A zero byte, or a byte whose lowest set bit is at position 4 or above, decodes to 0. Parent-line entries always decode this way. Core entries decode this way when `core_binary` is 0.
- R4: When `core_binary` is 1, a core entry's byte value is used directly as the core index.
- R5: If a decoded core entry equals the source's current target, no event is produced and the table is unchanged.
- R6: If a core entry changes the target of a source whose `pend` bit is set, the block first presents a lower event (`ev_level`=0, old core). It then updates the table when that event is accepted. It then presents a raise event (`ev_level`=1, new core) for the same source.
- R7: If a core entry changes the target of a source that is not pending, the table is updated and no event is produced.
- R8: Writes to the parent-line table update only the decoded line map and never produce an event, whatever `pend` holds.
- R9: `rd_data` returns the exact 32-bit word last written to the selected table and address.
- R10: After a write is accepted, `cfg_ready` stays low for one cycle per entry, plus one more cycle per event. Entries are handled in ascending order, so events for entry i come before events for entry i+1.
- R11: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_src`, `ev_core` and `ev_level` hold their values.
- R12: `core_binary` is sampled at the moment an entry is decoded. Changing it later does not change entries already in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Table word write request |
| cfg_ready | output | 1 | Block idle, able to take a word |
| cfg_table | input | 1 | 0 selects the core table, 1 selects the parent-line table |
| cfg_addr | input | 4 | Word address within the selected table |
| cfg_data | input | 32 | Four byte entries |
| core_binary | input | 1 | 1 selects binary core decoding, 0 selects one-hot decoding |
| pend | input | 64 | Raw pending bit per source |
| rd_table | input | 1 | Table selected for readback |
| rd_addr | input | 4 | Word address for readback |
| rd_data | output | 32 | Raw word as written |
| lk_src | input | 6 | Source to look up |
| lk_core | output | 8 | Decoded target core of `lk_src` |
| lk_line | output | 2 | Decoded parent line of the group that holds `lk_src` |
| ev_valid | output | 1 | Retarget event present |
| ev_ready | input | 1 | Router accepts the event |
| ev_src | output | 6 | Source number of the event |
| ev_core | output | 8 | Core the event applies to |
| ev_level | output | 1 | 0 lowers the source, 1 raises it |

## Verification
The assertions run on every cycle. They check that a stalled event keeps its values, that an accepted lower event is followed straight away by a raise for the same source, and that one-hot decoding never produces an index above 3. They also check that the walk of a parent-line word, or of a non-pending source, never sends an event, and that every decoded entry lands in its table slot. Other behaviours show only in the bench's scenarios, because they depend on values chosen by software. These are the exact decoded values of the fallback bytes, the byte-to-item placement, the core values carried by lower and raise events, the table updating between the two events, how long `cfg_ready` stays low, and the fact that a change of mode does not touch entries already stored.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENTRIES_PER_WORD = 4;
  localparam int ENTRY_W          = 8;
  localparam int WORD_W           = ENTRIES_PER_WORD * ENTRY_W;
  localparam logic TBL_CORE = 1'b0;
  localparam logic TBL_LINE = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_LOWER,
    ST_RAISE
  } seq_state_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int OUT_W        = 8,
  parameter int ONEHOT_LIMIT = 4
) (
  input  logic [irq_route_pkg::ENTRY_W-1:0] entry,
  input  logic                              binary_mode,
  output logic [OUT_W-1:0]                  idx
);
  logic hit;

  always_comb begin
    idx = '0;
    hit = 1'b0;
    if (binary_mode) begin
      idx = OUT_W'(entry);
    end else begin
      for (int b = 0; b < ONEHOT_LIMIT; b++) begin
        if (!hit && entry[b]) begin
          idx = OUT_W'(b);
          hit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int N_ENTRIES = 64,
  parameter int VAL_W     = 8,
  parameter int IN_W      = 6,
  parameter int ADDR_W    = 4,
  parameter int N_LK      = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           raw_we,
  input  logic [ADDR_W-1:0]              raw_addr,
  input  logic [irq_route_pkg::WORD_W-1:0] raw_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [irq_route_pkg::WORD_W-1:0] rd_word,
  input  logic                           ent_we,
  input  logic [IN_W-1:0]                ent_idx,
  input  logic [VAL_W-1:0]               ent_val,
  input  logic [N_LK-1:0][IN_W-1:0]      lk_idx,
  output logic [N_LK-1:0][VAL_W-1:0]     lk_val
);
  localparam int N_WORDS = (N_ENTRIES + irq_route_pkg::ENTRIES_PER_WORD - 1)
                           / irq_route_pkg::ENTRIES_PER_WORD;
  localparam int WLOC_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int ELOC_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [irq_route_pkg::WORD_W-1:0] raw_q [N_WORDS];
  logic [VAL_W-1:0]                 map_q [N_ENTRIES];

  logic [WLOC_W-1:0] wr_loc, rd_loc;
  logic [ELOC_W-1:0] ent_loc;
  logic              wr_ok, rd_ok, ent_ok;

  assign wr_loc  = raw_addr[WLOC_W-1:0];
  assign rd_loc  = rd_addr[WLOC_W-1:0];
  assign ent_loc = ent_idx[ELOC_W-1:0];
  assign wr_ok   = (int'(raw_addr) < N_WORDS);
  assign rd_ok   = (int'(rd_addr) < N_WORDS);
  assign ent_ok  = (int'(ent_idx) < N_ENTRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < N_WORDS; w++) raw_q[w] <= '0;
      for (int e = 0; e < N_ENTRIES; e++) map_q[e] <= '0;
    end else begin
      if (raw_we && wr_ok) raw_q[wr_loc] <= raw_data;
      if (ent_we && ent_ok) map_q[ent_loc] <= ent_val;
    end
  end

  assign rd_word = rd_ok ? raw_q[rd_loc] : '0;

  for (genvar k = 0; k < N_LK; k++) begin : g_lookup
    logic [ELOC_W-1:0] loc;
    assign loc       = lk_idx[k][ELOC_W-1:0];
    assign lk_val[k] = (int'(lk_idx[k]) < N_ENTRIES) ? map_q[loc] : '0;
  end

  // R2: a decoded entry lands in the slot of its item
  a_r2_entry_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && ent_ok) |=> (map_q[$past(ent_loc)] == $past(ent_val)));
endmodule

// File: rtl/irq_route_seq.sv
module irq_route_seq
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC      = 64,
  parameter int ADDR_W       = 4,
  parameter int ITEM_W       = 6,
  parameter int CORE_W       = 8,
  parameter int LINE_W       = 2,
  parameter int ONEHOT_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_table,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              core_binary,
  input  logic [NUM_SRC-1:0] pend,
  output logic [ITEM_W-1:0] item,
  input  logic [CORE_W-1:0] cur_core,
  output logic              core_we,
  output logic [CORE_W-1:0] core_val,
  output logic              line_we,
  output logic [LINE_W-1:0] line_val,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [ITEM_W-1:0] ev_src,
  output logic [CORE_W-1:0] ev_core,
  output logic              ev_level
);
  seq_state_e        state_q, state_d;
  logic [1:0]        idx_q;
  logic              tbl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [CORE_W-1:0] new_q;
  logic [ENTRY_W-1:0] entry;
  logic [CORE_W-1:0] dec_core;
  logic              advance, accept, go_lower;

  assign entry  = data_q[{idx_q, 3'b000} +: ENTRY_W];
  assign item   = {addr_q, idx_q};
  assign accept = cfg_valid && cfg_ready;

  irq_route_decode #(.OUT_W(CORE_W), .ONEHOT_LIMIT(ONEHOT_LIMIT)) u_dec_core (
    .entry(entry), .binary_mode(core_binary), .idx(dec_core));

  irq_route_decode #(.OUT_W(LINE_W), .ONEHOT_LIMIT(ONEHOT_LIMIT)) u_dec_line (
    .entry(entry), .binary_mode(1'b0), .idx(line_val));

  always_comb begin
    state_d   = state_q;
    cfg_ready = 1'b0;
    core_we   = 1'b0;
    core_val  = dec_core;
    line_we   = 1'b0;
    ev_valid  = 1'b0;
    ev_level  = 1'b0;
    ev_core   = cur_core;
    advance   = 1'b0;
    go_lower  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cfg_ready = 1'b1;
        if (cfg_valid) state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (tbl_q == TBL_LINE) begin
          line_we = 1'b1;
          advance = 1'b1;
        end else if (dec_core == cur_core) begin
          advance = 1'b1;
        end else if (pend[item]) begin
          go_lower = 1'b1;
          state_d  = ST_LOWER;
        end else begin
          core_we = 1'b1;
          advance = 1'b1;
        end
      end
      ST_LOWER: begin
        ev_valid = 1'b1;
        ev_level = 1'b0;
        ev_core  = cur_core;
        if (ev_ready) begin
          core_we  = 1'b1;
          core_val = new_q;
          state_d  = ST_RAISE;
        end
      end
      ST_RAISE: begin
        ev_valid = 1'b1;
        ev_level = 1'b1;
        ev_core  = new_q;
        if (ev_ready) advance = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (advance) state_d = (idx_q == 2'd3) ? ST_IDLE : ST_SCAN;
  end

  assign ev_src = item;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tbl_q   <= TBL_CORE;
      addr_q  <= '0;
      data_q  <= '0;
      new_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tbl_q  <= cfg_table;
        addr_q <= cfg_addr;
        data_q <= cfg_data;
        idx_q  <= '0;
      end else if (advance) begin
        idx_q <= idx_q + 2'd1;
      end
      if (go_lower) new_q <= dec_core;
    end
  end

  // R11: a stalled event keeps its contents
  a_r11_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_src) &&
                                 $stable(ev_core) && $stable(ev_level)));

  // R6: an accepted lower is followed by a raise for the same source
  a_r6_raise_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ev_level) |=> (ev_valid && ev_level && $stable(ev_src)));

  // R3: one-hot core decoding stays below the limit
  a_r3_onehot_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && tbl_q == TBL_CORE && !core_binary)
      |-> (int'(dec_core) < ONEHOT_LIMIT));

  // R8: walking a parent-line word never raises an event
  a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && tbl_q == TBL_LINE) |-> !ev_valid);

  // R7: a non-pending source never leads to an event
  a_r7_idle_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && tbl_q == TBL_CORE && !pend[item]) |=> !ev_valid);
endmodule

// File: rtl/irq_route_retarget.sv
module irq_route_retarget
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC      = 64,
  parameter int GROUP_SIZE   = 8,
  parameter int CORE_W       = 8,
  parameter int LINE_W       = 2,
  parameter int ONEHOT_LIMIT = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = $clog2(NUM_SRC / ENTRIES_PER_WORD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic               cfg_table,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0]  cfg_data,
  input  logic               core_binary,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               rd_table,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [SRC_W-1:0]   lk_src,
  output logic [CORE_W-1:0]  lk_core,
  output logic [LINE_W-1:0]  lk_line,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [SRC_W-1:0]   ev_src,
  output logic [CORE_W-1:0]  ev_core,
  output logic               ev_level
);
  localparam int NUM_GRP = NUM_SRC / GROUP_SIZE;
  localparam int GRP_SH  = $clog2(GROUP_SIZE);
  localparam int ITEM_W  = ADDR_W + 2;

  logic [ITEM_W-1:0] item;
  logic [CORE_W-1:0] cur_core;
  logic              core_we, line_we;
  logic [CORE_W-1:0] core_val;
  logic [LINE_W-1:0] line_val;
  logic              accept;
  logic [WORD_W-1:0] rd_core, rd_line;
  logic [1:0][ITEM_W-1:0] core_lk_idx;
  logic [1:0][CORE_W-1:0] core_lk_val;
  logic [0:0][ITEM_W-1:0] line_lk_idx;
  logic [0:0][LINE_W-1:0] line_lk_val;

  assign accept = cfg_valid && cfg_ready;

  irq_route_seq #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ITEM_W(ITEM_W),
    .CORE_W(CORE_W), .LINE_W(LINE_W), .ONEHOT_LIMIT(ONEHOT_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_table(cfg_table),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .core_binary(core_binary),
    .pend(pend), .item(item), .cur_core(cur_core),
    .core_we(core_we), .core_val(core_val),
    .line_we(line_we), .line_val(line_val),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src),
    .ev_core(ev_core), .ev_level(ev_level)
  );

  assign core_lk_idx[0] = ITEM_W'(lk_src);
  assign core_lk_idx[1] = item;
  assign lk_core        = core_lk_val[0];
  assign cur_core       = core_lk_val[1];

  irq_route_table #(
    .N_ENTRIES(NUM_SRC), .VAL_W(CORE_W), .IN_W(ITEM_W),
    .ADDR_W(ADDR_W), .N_LK(2)
  ) u_core_tbl (
    .clk(clk), .rst_n(rst_n),
    .raw_we(accept && cfg_table == TBL_CORE), .raw_addr(cfg_addr), .raw_data(cfg_data),
    .rd_addr(rd_addr), .rd_word(rd_core),
    .ent_we(core_we), .ent_idx(item), .ent_val(core_val),
    .lk_idx(core_lk_idx), .lk_val(core_lk_val)
  );

  assign line_lk_idx[0] = ITEM_W'(lk_src >> GRP_SH);
  assign lk_line        = line_lk_val[0];

  irq_route_table #(
    .N_ENTRIES(NUM_GRP), .VAL_W(LINE_W), .IN_W(ITEM_W),
    .ADDR_W(ADDR_W), .N_LK(1)
  ) u_line_tbl (
    .clk(clk), .rst_n(rst_n),
    .raw_we(accept && cfg_table == TBL_LINE), .raw_addr(cfg_addr), .raw_data(cfg_data),
    .rd_addr(rd_addr), .rd_word(rd_line),
    .ent_we(line_we), .ent_idx(item), .ent_val(line_val),
    .lk_idx(line_lk_idx), .lk_val(line_lk_val)
  );

  assign rd_data = (rd_table == TBL_LINE) ? rd_line : rd_core;
endmodule

// File: tb/irq_route_retarget_bench.sv
`timescale 1ns/1ps
module irq_route_retarget_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_table = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        core_binary = 1'b0;
  logic [63:0] pend = '0;
  logic        rd_table = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  lk_src = '0;
  logic [7:0]  lk_core;
  logic [1:0]  lk_line;
  logic        ev_valid;
  logic        ev_ready = 1'b1;
  logic [5:0]  ev_src;
  logic [7:0]  ev_core;
  logic        ev_level;

  int checks = 0;
  int errors = 0;
  int ev_n = 0;
  int log_src [0:63];
  int log_core [0:63];
  int log_lvl [0:63];
  int busy_cycles = 0;

  always #2 clk = ~clk;

  irq_route_retarget u_irq_route_retarget (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_table(cfg_table), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .core_binary(core_binary), .pend(pend), .rd_table(rd_table),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_src(lk_src), .lk_core(lk_core),
    .lk_line(lk_line), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_core(ev_core), .ev_level(ev_level)
  );

  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready && ev_n < 64) begin
      log_src[ev_n]  = int'(ev_src);
      log_core[ev_n] = int'(ev_core);
      log_lvl[ev_n]  = int'(ev_level);
      ev_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic core_of(input int src, output int val);
    lk_src = 6'(src);
    #0.1;
    val = int'(lk_core);
  endtask

  task automatic line_of(input int src, output int val);
    lk_src = 6'(src);
    #0.1;
    val = int'(lk_line);
  endtask

  task automatic raw_of(input bit tbl, input int addr, output int val);
    rd_table = tbl;
    rd_addr  = 4'(addr);
    #0.1;
    val = int'(rd_data);
  endtask

  // drive one word, wait for its walk to finish; busy_cycles counts ready-low negedges
  task automatic wr(input bit tbl, input int addr, input logic [31:0] data);
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_table = tbl; cfg_addr = 4'(addr); cfg_data = data;
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    busy_cycles = 0;
    @(negedge clk);
    while (!cfg_ready) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    check_eq("R1 ready", int'(cfg_ready), 1);
    check_eq("R1 ev_valid", int'(ev_valid), 0);
    core_of(0, v);  check_eq("R1 core src0", v, 0);
    core_of(37, v); check_eq("R1 core src37", v, 0);
    line_of(63, v); check_eq("R1 line src63", v, 0);
    raw_of(1'b0, 5, v); check_eq("R1 raw core word5", v, 0);
  endtask

  task automatic t_onehot_layout;
    int v, n0;
    core_binary = 1'b0; pend = '0; n0 = ev_n;
    wr(1'b0, 2, 32'h06_00_04_08);
    core_of(8, v);  check_eq("R2 R3 src8 bit3", v, 3);
    core_of(9, v);  check_eq("R2 R3 src9 bit2", v, 2);
    core_of(10, v); check_eq("R3 src10 empty", v, 0);
    core_of(11, v); check_eq("R3 src11 lowest bit1", v, 1);
    check_eq("R10 busy cycles, no events", busy_cycles, 4);
    wr(1'b0, 3, 32'h30_0C_01_80);
    core_of(12, v); check_eq("R3 src12 bit7 fallback", v, 0);
    core_of(14, v); check_eq("R3 src14 lowest bit2", v, 2);
    core_of(15, v); check_eq("R3 src15 bit4 fallback", v, 0);
    raw_of(1'b0, 3, v); check_eq("R9 raw core word3", v, 32'h30_0C_01_80);
    check_eq("R7 no events", ev_n - n0, 0);
  endtask

  task automatic t_binary;
    int v;
    core_binary = 1'b1;
    wr(1'b0, 4, 32'hC8_07_00_05);
    core_of(16, v); check_eq("R4 src16", v, 5);
    core_of(18, v); check_eq("R4 src18", v, 7);
    core_of(19, v); check_eq("R4 src19", v, 200);
  endtask

  task automatic t_line;
    int v, n0;
    pend = '1; n0 = ev_n;
    wr(1'b1, 1, 32'h01_20_02_08);
    line_of(32, v); check_eq("R2 R3 group4 line", v, 3);
    line_of(45, v); check_eq("R2 R3 group5 line", v, 1);
    line_of(50, v); check_eq("R3 group6 bit5 fallback", v, 0);
    line_of(0, v);  check_eq("R1 group0 untouched", v, 0);
    raw_of(1'b1, 1, v); check_eq("R9 raw line word1", v, 32'h01_20_02_08);
    check_eq("R8 line write no events", ev_n - n0, 0);
    core_of(8, v); check_eq("R8 core table untouched", v, 3);
    pend = '0;
  endtask

  task automatic t_same_target;
    int v, n0;
    core_binary = 1'b1; pend = 64'h0000_0000_000F_0000; n0 = ev_n;
    wr(1'b0, 4, 32'hC8_07_00_05);
    check_eq("R5 same target no events", ev_n - n0, 0);
    check_eq("R5 R10 busy cycles", busy_cycles, 4);
    core_of(16, v); check_eq("R5 src16 kept", v, 5);
    pend = '0;
  endtask

  task automatic t_live_order;
    int n0, v;
    core_binary = 1'b1; ev_ready = 1'b1;
    pend = 64'h0000_0000_00F0_0000; n0 = ev_n;
    wr(1'b0, 5, 32'h04_03_02_01);
    check_eq("R6 event count", ev_n - n0, 8);
    check_eq("R10 busy cycles with events", busy_cycles, 12);
    for (int k = 0; k < 4; k++) begin
      check_eq("R10 lower src order", log_src[n0 + 2*k], 20 + k);
      check_eq("R6 lower level", log_lvl[n0 + 2*k], 0);
      check_eq("R6 lower old core", log_core[n0 + 2*k], 0);
      check_eq("R6 raise src", log_src[n0 + 2*k + 1], 20 + k);
      check_eq("R6 raise level", log_lvl[n0 + 2*k + 1], 1);
      check_eq("R6 raise new core", log_core[n0 + 2*k + 1], k + 1);
    end
    core_of(23, v); check_eq("R6 src23 updated", v, 4);
    pend = '0;
  endtask

  task automatic t_backpressure;
    int v;
    core_binary = 1'b1; ev_ready = 1'b0;
    pend = 64'h0000_0000_0100_0000;
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_table = 1'b0; cfg_addr = 4'd6; cfg_data = 32'h00_00_00_09;
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R11 lower held valid", int'(ev_valid), 1);
    check_eq("R11 lower held level", int'(ev_level), 0);
    check_eq("R11 lower held src", int'(ev_src), 24);
    check_eq("R6 lower carries old core", int'(ev_core), 0);
    check_eq("R10 busy during stall", int'(cfg_ready), 0);
    core_of(24, v); check_eq("R6 table old before lower taken", v, 0);
    @(posedge clk); #1;
    ev_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R6 raise level", int'(ev_level), 1);
    check_eq("R6 raise new core", int'(ev_core), 9);
    core_of(24, v); check_eq("R6 table new between events", v, 9);
    while (!cfg_ready) @(negedge clk);
    pend = '0;
  endtask

  task automatic t_mode_sample;
    int v;
    core_binary = 1'b1;
    wr(1'b0, 7, 32'h00_00_00_05);
    core_binary = 1'b0;
    @(negedge clk);
    core_of(28, v); check_eq("R12 stored entry kept after mode change", v, 5);
    wr(1'b0, 7, 32'h00_00_00_05);
    core_of(28, v); check_eq("R12 one-hot decode at write", v, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_onehot_layout();
    t_binary();
    t_line();
    t_same_target();
    t_live_order();
    t_backpressure();
    t_mode_sample();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule